// File: doc/BRIEF.md
# Thermometer-Coded Power-of-Two Clock Divider

This block divides its input clock by 1, 2, 4, 8 or 16. The ratio is chosen by a 4-bit code taken from a field of a 32-bit control word. The number of ones in the code is the base-two logarithm of the ratio, so the only accepted codes are 0x0, 0x1, 0x3, 0x7 and 0xF. A load strobe offers a new control word. A valid code is queued and takes effect only when the current output period has finished, so the divided clock never shows a short high or low phase. A code that is not a thermometer pattern is refused, the running ratio is kept, and an error flag is raised.

Two outputs carry the divided rate. The first is a divided clock with a 50 percent duty cycle; at ratio one it is the input clock itself. The second is a one-cycle enable pulse that marks the last input cycle of every output period, for logic that runs in the single input clock domain. A separate combinational helper turns a parent rate and a target rate into the matching code. It computes the ceiling of their quotient minus one and reports whether the result is a usable thermometer code.

Top module: `therm_clk_div`

## Requirements
- R1: After a synchronous active-low reset, the applied code is 0x0 (ratio 1), the error flag is low and the enable pulse is high on every cycle.
- R2: The code is read from bits 11:8 of the control word, and only on a cycle with the load strobe high. All other bits of the word have no effect.
- R3: The applied codes 0x0, 0x1, 0x3, 0x7 and 0xF give output periods of 1, 2, 4, 8 and 16 input cycles. The applied code is always one of these five.
- R4: A loaded code that is not a thermometer pattern is refused and does not change the running or queued ratio. The error flag goes high on the next cycle and stays high until a valid code is loaded, which clears it.
- R5: A valid loaded code is applied only at the clock edge that ends a cycle in which the enable pulse is high. A new output period, starting at phase zero, begins at that edge.
- R6: The enable pulse is high in exactly the last input cycle of each output period. At code 0x0 it is high in every cycle.
- R7: For ratios N greater than one, the divided clock is high for the first N/2 cycles of each period and low for the last N/2. At ratio one, the divided clock equals the input clock.
- R8: The helper code is min(ceil(parent/target), 16) − 1, with a zero parent giving 0x0. The helper valid flag is high only when the target is nonzero, the quotient ceiling is at most 16 and the code is a thermometer pattern.
- R9: A second valid load made while a code is still queued replaces the queued code. The later code is the one applied at the period end.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Input clock |
| rst_ni | input | 1 | Synchronous active-low reset |
| ctrl_word_i | input | 32 | Control word; code field in bits 11:8 |
| ctrl_load_i | input | 1 | Strobe that offers ctrl_word_i |
| parent_rate_i | input | 32 | Helper: parent clock rate |
| target_rate_i | input | 32 | Helper: requested output rate |
| clk_div_o | output | 1 | Divided clock, 50 percent duty |
| tick_o | output | 1 | Enable pulse in the last cycle of each output period |
| cur_code_o | output | 4 | Code currently in force |
| code_err_o | output | 1 | High after a refused code load |
| helper_code_o | output | 4 | Code computed from the rate pair |
| helper_ok_o | output | 1 | Helper code is an exact thermometer code |

## Verification
The hardest case to reach from the ports is a load that lands while another code is already queued inside a long ratio-16 period. Near that case is a load that arrives on the very edge where the period closes. Without care, both the queue overwrite and the apply-versus-load ordering go unseen. The stimulus therefore switches to ratio 16 and issues dense loads, both valid and invalid, on random cycles. Directed sequences queue two codes back to back inside one period. A cycle-level reference model built from the requirements predicts the applied code, the phase, the pulse and the clock level on every cycle.

// File: rtl/tdiv_pkg.sv
`timescale 1ns/1ps
// Package tdiv_pkg
// Purpose : shared helpers for the thermometer-coded divider.
// Assumes : codes are at most 15 bits wide and are zero-extended to 16.
package tdiv_pkg;

    localparam int unsigned TDIV_VEC_W = 16;

    // True when v is a run of ones starting at bit 0, or zero.
    function automatic logic thermo_ok(input logic [TDIV_VEC_W-1:0] v);
        logic [TDIV_VEC_W-1:0] inc;
        inc = v + 1'b1;
        return ((inc & v) == '0);
    endfunction

    // Number of ones, which is log2 of the ratio for a valid code.
    function automatic int unsigned thermo_len(input logic [TDIV_VEC_W-1:0] v);
        return $countones(v);
    endfunction

endpackage

// File: rtl/tdiv_code_check.sv
`timescale 1ns/1ps
// Module  : tdiv_code_check
// Purpose : extracts the ratio code from the control word, tests whether it
//           is a thermometer pattern and gives its log2 ratio.
// Assumes : the field lies wholly inside the word (CODE_LSB+CODE_W <= CTRL_W).
module tdiv_code_check
    import tdiv_pkg::*;
#(
    parameter int unsigned CTRL_W   = 32,
    parameter int unsigned CODE_LSB = 8,
    parameter int unsigned CODE_W   = 4,
    localparam int unsigned LG_W    = $clog2(CODE_W + 1)
) (
    input  logic [CTRL_W-1:0] ctrl_word_i,
    output logic [CODE_W-1:0] code_o,
    output logic              code_ok_o,
    output logic [LG_W-1:0]   code_lg_o
);

    localparam logic [CTRL_W-1:0] FIELD_MASK =
        ((CTRL_W'(1) << CODE_W) - CTRL_W'(1)) << CODE_LSB;

    logic ctrl_unused;

    // Field slice and validity test.
    always_comb begin
        code_o    = ctrl_word_i[CODE_LSB +: CODE_W];
        code_ok_o = thermo_ok(TDIV_VEC_W'(code_o));
        code_lg_o = LG_W'(thermo_len(TDIV_VEC_W'(code_o)));
    end

    // Bits outside the field carry no meaning for this block.
    assign ctrl_unused = |(ctrl_word_i & ~FIELD_MASK);

endmodule

// File: rtl/tdiv_ratio_ctrl.sv
`timescale 1ns/1ps
// Module  : tdiv_ratio_ctrl
// Purpose : holds the applied ratio, queues a newly loaded valid code and
//           swaps it in at the end of an output period; flags refused codes.
// Assumes : period_end_i is high in the last cycle of each output period.
module tdiv_ratio_ctrl #(
    parameter int unsigned CODE_W = 4,
    localparam int unsigned LG_W  = $clog2(CODE_W + 1)
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              load_i,
    input  logic [CODE_W-1:0] cand_code_i,
    input  logic              cand_ok_i,
    input  logic [LG_W-1:0]   cand_lg_i,
    input  logic              period_end_i,
    output logic [CODE_W-1:0] act_code_o,
    output logic [LG_W-1:0]   act_lg_o,
    output logic [LG_W-1:0]   nxt_lg_o,
    output logic              err_o
);

    logic [CODE_W-1:0] act_code_q, pend_code_q;
    logic [LG_W-1:0]   act_lg_q, pend_lg_q;
    logic              pend_v_q, err_q;
    logic              swap;

    // Swap happens on the edge that closes a period with a code queued.
    assign swap = period_end_i && pend_v_q;

    // Log2 ratio that will be in force after the coming edge.
    always_comb begin
        nxt_lg_o = swap ? pend_lg_q : act_lg_q;
    end

    // Applied and queued ratio registers with error flag.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            act_code_q  <= '0;
            act_lg_q    <= '0;
            pend_code_q <= '0;
            pend_lg_q   <= '0;
            pend_v_q    <= 1'b0;
            err_q       <= 1'b0;
        end else begin
            if (swap) begin
                act_code_q <= pend_code_q;
                act_lg_q   <= pend_lg_q;
                pend_v_q   <= 1'b0;
            end
            if (load_i) begin
                if (cand_ok_i) begin
                    pend_code_q <= cand_code_i;
                    pend_lg_q   <= cand_lg_i;
                    pend_v_q    <= 1'b1;
                    err_q       <= 1'b0;
                end else begin
                    err_q       <= 1'b1;
                end
            end
        end
    end

    assign act_code_o = act_code_q;
    assign act_lg_o   = act_lg_q;
    assign err_o      = err_q;

endmodule

// File: rtl/tdiv_phase_gen.sv
`timescale 1ns/1ps
// Module  : tdiv_phase_gen
// Purpose : counts input cycles within an output period, marks the last
//           cycle and produces a registered half-high, half-low clock level.
// Assumes : lg_nxt_i is the log2 ratio valid after the coming edge.
module tdiv_phase_gen #(
    parameter int unsigned CNT_W = 4,
    localparam int unsigned LG_W = $clog2(CNT_W + 1),
    localparam int unsigned SPAN_W = CNT_W + 1
) (
    input  logic            clk_i,
    input  logic            rst_ni,
    input  logic [LG_W-1:0] lg_now_i,
    input  logic [LG_W-1:0] lg_nxt_i,
    output logic            period_end_o,
    output logic            level_o
);

    logic [CNT_W-1:0]  cnt_q, cnt_nxt, cnt_last;
    logic [SPAN_W-1:0] span_now, span_nxt;
    logic              level_q, level_nxt;

    // Period length now and after the edge.
    always_comb begin
        span_now = SPAN_W'(1) << lg_now_i;
        span_nxt = SPAN_W'(1) << lg_nxt_i;
        cnt_last = CNT_W'(span_now - SPAN_W'(1));
    end

    // Next phase and next output level.
    always_comb begin
        period_end_o = (cnt_q == cnt_last);
        cnt_nxt      = period_end_o ? '0 : cnt_q + 1'b1;
        level_nxt    = ({1'b0, cnt_nxt} < (span_nxt >> 1));
    end

    // Phase counter and output level register.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            cnt_q   <= '0;
            level_q <= 1'b0;
        end else begin
            cnt_q   <= cnt_nxt;
            level_q <= level_nxt;
        end
    end

    assign level_o = level_q;

endmodule

// File: rtl/tdiv_rate_helper.sv
`timescale 1ns/1ps
// Module  : tdiv_rate_helper
// Purpose : turns a parent/target rate pair into the ratio code
//           ceil(parent/target)-1, saturated, and says if it is exact.
// Assumes : combinational use; one comparator per possible ratio.
module tdiv_rate_helper
    import tdiv_pkg::*;
#(
    parameter int unsigned RATE_W = 32,
    parameter int unsigned CODE_W = 4,
    localparam int unsigned NK    = 1 << CODE_W,
    localparam int unsigned PW    = RATE_W + CODE_W + 1
) (
    input  logic [RATE_W-1:0] parent_i,
    input  logic [RATE_W-1:0] target_i,
    output logic [CODE_W-1:0] code_o,
    output logic              ok_o
);

    logic [NK-1:0] covers;
    logic          found;

    // covers[k-1]: k times the target reaches the parent rate.
    for (genvar k = 1; k <= NK; k++) begin : g_mult
        logic [PW-1:0] prod;
        assign prod          = PW'(target_i) * PW'(k);
        assign covers[k-1]   = (prod >= PW'(parent_i));
    end

    // Smallest covering multiple picks the code.
    always_comb begin
        code_o = '1;
        found  = 1'b0;
        for (int i = NK - 1; i >= 0; i--) begin
            if (covers[i]) begin
                code_o = CODE_W'(i);
                found  = 1'b1;
            end
        end
        ok_o = (target_i != '0) && found && thermo_ok(TDIV_VEC_W'(code_o));
    end

endmodule

// File: rtl/therm_clk_div.sv
`timescale 1ns/1ps
// Module  : therm_clk_div
// Purpose : power-of-two clock divider selected by a thermometer code with
//           glitch-free ratio changes, plus a rate-to-code helper.
// Assumes : single input clock; synchronous active-low reset.
module therm_clk_div #(
    parameter int unsigned CTRL_W   = 32,
    parameter int unsigned CODE_LSB = 8,
    parameter int unsigned CODE_W   = 4,
    parameter int unsigned RATE_W   = 32
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic [CTRL_W-1:0] ctrl_word_i,
    input  logic              ctrl_load_i,
    input  logic [RATE_W-1:0] parent_rate_i,
    input  logic [RATE_W-1:0] target_rate_i,
    output logic              clk_div_o,
    output logic              tick_o,
    output logic [CODE_W-1:0] cur_code_o,
    output logic              code_err_o,
    output logic [CODE_W-1:0] helper_code_o,
    output logic              helper_ok_o
);

    localparam int unsigned LG_W = $clog2(CODE_W + 1);

    logic [CODE_W-1:0] cand_code;
    logic              cand_ok;
    logic [LG_W-1:0]   cand_lg, act_lg, nxt_lg;
    logic              period_end, level;

    tdiv_code_check #(
        .CTRL_W(CTRL_W), .CODE_LSB(CODE_LSB), .CODE_W(CODE_W)
    ) u_check (
        .ctrl_word_i(ctrl_word_i),
        .code_o     (cand_code),
        .code_ok_o  (cand_ok),
        .code_lg_o  (cand_lg)
    );

    tdiv_ratio_ctrl #(.CODE_W(CODE_W)) u_ctrl (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .load_i      (ctrl_load_i),
        .cand_code_i (cand_code),
        .cand_ok_i   (cand_ok),
        .cand_lg_i   (cand_lg),
        .period_end_i(period_end),
        .act_code_o  (cur_code_o),
        .act_lg_o    (act_lg),
        .nxt_lg_o    (nxt_lg),
        .err_o       (code_err_o)
    );

    tdiv_phase_gen #(.CNT_W(CODE_W)) u_phase (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .lg_now_i    (act_lg),
        .lg_nxt_i    (nxt_lg),
        .period_end_o(period_end),
        .level_o     (level)
    );

    tdiv_rate_helper #(.RATE_W(RATE_W), .CODE_W(CODE_W)) u_helper (
        .parent_i(parent_rate_i),
        .target_i(target_rate_i),
        .code_o  (helper_code_o),
        .ok_o    (helper_ok_o)
    );

    // Ratio one passes the input clock; otherwise the registered level.
    assign clk_div_o = (act_lg == '0) ? clk_i : level;
    assign tick_o    = period_end;

endmodule

// File: rtl/therm_clk_div_chk.sv
`timescale 1ns/1ps
// Module  : therm_clk_div_chk
// Purpose : temporal checks on the divider's ports, bound to the top.
// Assumes : sampled on the input clock with synchronous reset.
module therm_clk_div_chk
    import tdiv_pkg::*;
#(
    parameter int unsigned CODE_W = 4
) (
    input logic              clk_i,
    input logic              rst_ni,
    input logic              ctrl_load_i,
    input logic              clk_div_o,
    input logic              tick_o,
    input logic [CODE_W-1:0] cur_code_o,
    input logic              code_err_o,
    input logic [CODE_W-1:0] helper_code_o,
    input logic              helper_ok_o
);

    assert_code_thermo_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        thermo_ok(TDIV_VEC_W'(cur_code_o)));

    assert_swap_at_end_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !$stable(cur_code_o) |-> $past(tick_o));

    assert_err_from_load_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(code_err_o) |-> $past(ctrl_load_i));

    assert_bypass_tick_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (cur_code_o == '0) |-> tick_o);

    assert_low_at_end_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (tick_o && cur_code_o != '0) |-> !clk_div_o);

    assert_helper_exact_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        helper_ok_o |-> thermo_ok(TDIV_VEC_W'(helper_code_o)));

endmodule

bind therm_clk_div therm_clk_div_chk #(.CODE_W(CODE_W)) chk_i (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .ctrl_load_i  (ctrl_load_i),
    .clk_div_o    (clk_div_o),
    .tick_o       (tick_o),
    .cur_code_o   (cur_code_o),
    .code_err_o   (code_err_o),
    .helper_code_o(helper_code_o),
    .helper_ok_o  (helper_ok_o)
);

// File: tb/therm_clk_div_tb_top.sv
`timescale 1ns/1ps
// Bench for therm_clk_div: cycle reference model, directed and random loads.
module therm_clk_div_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] word = '0;
    logic        load = 1'b0;
    logic [31:0] prate = 32'd100;
    logic [31:0] trate = 32'd100;
    logic        clk_div, tick, err, h_ok;
    logic [3:0]  cur_code, h_code;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    // Reference model state.
    logic [3:0] m_act = '0, m_pend = '0;
    bit         m_pv = 1'b0, m_err = 1'b0;
    int         m_cnt = 0;

    always #4 clk = ~clk;

    therm_clk_div dut_i (
        .clk_i(clk), .rst_ni(rst_n), .ctrl_word_i(word), .ctrl_load_i(load),
        .parent_rate_i(prate), .target_rate_i(trate),
        .clk_div_o(clk_div), .tick_o(tick), .cur_code_o(cur_code),
        .code_err_o(err), .helper_code_o(h_code), .helper_ok_o(h_ok)
    );

    function automatic bit is_thermo(input logic [3:0] c);
        return (c == 4'h0 || c == 4'h1 || c == 4'h3 || c == 4'h7 || c == 4'hF);
    endfunction

    function automatic int period_of(input logic [3:0] c);
        return 1 << $countones(c);
    endfunction

    function automatic logic [4:0] ref_helper(input logic [31:0] p, input logic [31:0] t);
        longint k;
        logic [3:0] c;
        bit ok;
        if (t == 0) return {1'b0, (p == 0) ? 4'h0 : 4'hF};
        k = (p == 0) ? 1 : (longint'(p) + longint'(t) - 1) / longint'(t);
        if (k > 16) return {1'b0, 4'hF};
        c = 4'(k - 1);
        ok = is_thermo(c);
        return {ok, c};
    endfunction

    // Reference model advanced on the same edge as the design.
    always @(posedge clk) begin
        if (!rst_n) begin
            m_act <= '0; m_pend <= '0; m_pv <= 1'b0; m_err <= 1'b0; m_cnt <= 0;
        end else begin
            if (m_cnt == period_of(m_act) - 1) begin
                m_cnt <= 0;
                if (m_pv) begin m_act <= m_pend; m_pv <= 1'b0; end
            end else begin
                m_cnt <= m_cnt + 1;
            end
            if (load) begin
                if (is_thermo(word[11:8])) begin
                    m_pend <= word[11:8]; m_pv <= 1'b1; m_err <= 1'b0;
                end else begin
                    m_err <= 1'b1;
                end
            end
        end
    end

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic report();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    endtask

    // One cycle: sample at the falling edge against the model, then drive.
    task automatic step(input logic ld, input logic [31:0] w);
        logic [4:0] hr;
        @(negedge clk);
        check("R3 applied code", 32'(cur_code), 32'(m_act));
        check("R4 error flag", 32'(err), 32'(m_err));
        check("R6 tick", 32'(tick), 32'(m_cnt == period_of(m_act) - 1));
        check("R7 divided clock", 32'(clk_div),
              (m_act == 0) ? 32'd0 : 32'(m_cnt < period_of(m_act) / 2));
        hr = ref_helper(prate, trate);
        check("R8 helper code", 32'(h_code), 32'(hr[3:0]));
        check("R8 helper ok", 32'(h_ok), 32'(hr[4]));
        load = ld;
        word = w;
    endtask

    task automatic helper_case(input logic [31:0] p, input logic [31:0] t,
                               input logic [3:0] ec, input logic eo);
        @(negedge clk);
        prate = p; trate = t;
        #1;
        check("R8 directed code", 32'(h_code), 32'(ec));
        check("R8 directed ok", 32'(h_ok), 32'(eo));
    endtask

    // Watchdog: an expired run is a failed check.
    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        report();
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        check("R1 reset code", 32'(cur_code), 32'h0);
        check("R1 reset error", 32'(err), 32'h0);
        check("R1 reset tick", 32'(tick), 32'h1);
        step(1'b0, '0);
        step(1'b0, '0);
        check("R1 tick every cycle", 32'(tick), 32'h1);

        // R2: field in bits 11:8, other bits ignored.
        step(1'b1, 32'hA5A5_F3A5);
        step(1'b0, 32'hFFFF_F0FF);
        step(1'b0, '0);
        check("R2 code from field", 32'(cur_code), 32'h3);
        repeat (10) step(1'b0, '0);

        // R4: refused code keeps ratio and raises the flag.
        step(1'b1, 32'h0000_0500);
        step(1'b0, '0);
        check("R4 flag after bad code", 32'(err), 32'h1);
        repeat (6) step(1'b0, '0);
        check("R4 ratio kept", 32'(cur_code), 32'h3);

        // R9: two valid loads inside one long period.
        step(1'b1, 32'h0000_0F00);
        repeat (8) step(1'b0, '0);
        repeat (3) step(1'b0, '0);
        check("R4 flag cleared by valid load", 32'(err), 32'h0);
        repeat (3) step(1'b0, '0);
        step(1'b1, 32'h0000_0700);
        step(1'b1, 32'h0000_0100);
        repeat (20) step(1'b0, '0);
        check("R9 later code wins", 32'(cur_code), 32'h1);

        // R8 directed helper corners.
        helper_case(32'd100, 32'd100, 4'h0, 1'b1);
        helper_case(32'd400, 32'd100, 4'h3, 1'b1);
        helper_case(32'd300, 32'd100, 4'h2, 1'b0);
        helper_case(32'd1600, 32'd100, 4'hF, 1'b1);
        helper_case(32'd1700, 32'd100, 4'hF, 1'b0);
        helper_case(32'd0, 32'd7, 4'h0, 1'b1);
        helper_case(32'd5, 32'd0, 4'hF, 1'b0);

        // Random phase: mostly valid codes, dense loads, random helper pairs.
        for (int i = 0; i < 4000; i++) begin
            logic [3:0]  c;
            logic [31:0] w;
            logic        ld;
            int          sel;
            sel = $urandom_range(0, 9);
            case (sel)
                0: c = 4'h0;
                1: c = 4'h1;
                2: c = 4'h3;
                3: c = 4'h7;
                4, 5: c = 4'hF;
                default: c = 4'($urandom_range(0, 15));
            endcase
            w = $urandom();
            w[11:8] = c;
            ld = ($urandom_range(0, 5) == 0);
            trate = $urandom_range(1, 1000);
            prate = trate * $urandom_range(0, 18) + $urandom_range(0, 2) * $urandom_range(0, trate);
            step(ld, w);
        end
        step(1'b0, '0);
        report();
    end

endmodule